// File: doc/BRIEF.md
# Descriptor Ring Master Controller

This block is the host-side control unit of a serial management bus master. Software places 16-byte transfer descriptors in a ring in memory. It programs the ring's base address and size through a small register port, and then moves a head pointer forward to queue work. While the start bit is set and the hardware tail pointer differs from the head, the controller does the following for each pending descriptor:

- reads it through a memory request/response port;
- hands its fields to a transaction executor;
- collects the executor's result and writes the result bytes back into the descriptor;
- advances the tail and updates its interrupt status.

The memory request channel, the executor hand-off and the result channel are valid/ready streams. Back-pressure follows these rules:

- A request or hand-off, once valid, keeps its payload stable until ready is sampled high.
- The controller keeps one memory read outstanding at a time.
- A memory response is always accepted in the cycle it arrives.
- Writes complete when they are accepted, with no response.
- `res_ready` is high only while the controller waits for a result. The executor may hold `res_valid` for as long as it needs.

Top module: `dring_ctrl`

Register word addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | base low |
| 1 | base high |
| 2 | control |
| 3 | status |
| 4 | ring size |
| 5 | timing |

Control bits: bit 0 is start, bit 4 is error-interrupt enable, bits 23:16 are the head. Status bits: bit 0 is in progress, bit 4 is the error interrupt, bit 5 is the completion interrupt, bits 23:16 are the tail.

Descriptor bytes, little-endian:

| Bytes | Content |
|---|---|
| 0 | target address with R/W |
| 1 | write length or command |
| 2 | read length |
| 3 | control |
| 4 | status |
| 5 | retry |
| 6 | received count |
| 7 | transmitted count |
| 8-15 | 64-bit data pointer |

## Requirements
- R1: After reset the status and control registers read 0, `irq` is low and no memory request is valid.
- R2: Base low/high, ring size (low 8 bits = entries minus one) and timing read back as written. `speed_sel` equals timing bits 31:30, with 00 = 80 kHz, 01 = 100 kHz, 10 = 400 kHz and 11 = 1 MHz.
- R3: For each descriptor the controller issues exactly three reads, in order, at base+16*tail+0, +8 and +12. The result word at +4 is not fetched.
- R4: The executor receives byte 0 as target, byte 1 as write length, byte 2 as read length, byte 3 as control, and words +8/+12 as the low/high halves of the data pointer. These are held stable until `exec_ready`.
- R5: Writeback is one write to base+16*tail+4 with strobe 4'b1101. Status goes in byte 0, received count in byte 2 and transmitted count in byte 3. The retry byte in memory is left unchanged.
- R6: The tail advances by one after each writeback, and wraps from the ring-size value to 0. It changes at no other time.
- R7: Status bit 0 reads 1 while a descriptor is being processed. It reads 0 once the tail equals the head, and then no request or hand-off is valid.
- R8: Writing start as 0 while a descriptor is in flight lets that descriptor finish, then stops before the next one. Writing start as 1 again resumes from the tail.
- R9: Status bit 5 (completion) is set after a writeback only if the descriptor's control bit 6 is 1.
- R10: Status bit 4 (error) is set after a writeback whose result status has bit 0 clear, and only if control bit 4 is 1.
- R11: Writing 1 to status bit 4 or 5 clears that bit, and writing 0 leaves it. `irq` is high while either bit is set.
- R12: A memory request held by low `mem_req_ready` keeps its address and direction until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_wstrb | output | 4 | Write byte strobes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| exec_valid | output | 1 | Descriptor offered to executor |
| exec_ready | input | 1 | Executor takes descriptor |
| exec_tgt | output | 8 | Target address with R/W |
| exec_wr_len | output | 8 | Write length or command |
| exec_rd_len | output | 8 | Read length |
| exec_ctrl | output | 8 | Descriptor control byte |
| exec_dptr | output | 64 | Data pointer |
| res_valid | input | 1 | Result valid |
| res_ready | output | 1 | Controller waiting for result |
| res_status | input | 8 | Result status, bit 0 = success |
| res_rx_cnt | input | 8 | Bytes received |
| res_tx_cnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |
| speed_sel | output | 2 | Bus speed select |

## Verification
A wrong tail shows up at the very next read: the request address lands in the wrong slot. It also shows up at once in status bits 23:16. A state machine stuck or skipping states shows as a missing or extra hand-off or writeback within a few cycles, or as the in-progress bit staying high. Wrong interrupt-bit handling is visible on `irq` the cycle after the writeback is accepted. Failing to honour a stop shows as an extra descriptor fetch right after the current writeback.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd1;
  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd2;
  localparam logic [REG_AW-1:0] RA_STAT    = 3'd3;
  localparam logic [REG_AW-1:0] RA_SIZE    = 3'd4;
  localparam logic [REG_AW-1:0] RA_TIMING  = 3'd5;

  localparam int CTRL_GO    = 0;
  localparam int CTRL_ERRIE = 4;
  localparam int PTR_LSB    = 16;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_ERR   = 4;
  localparam int STAT_DONE  = 5;
  localparam int DESC_IRQ   = 6;
  localparam int RES_OK     = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_RSP, S_EXEC, S_WAIT, S_WB
  } seq_state_t;
endpackage

// File: rtl/dring_regs.sv
module dring_regs
  import dring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PTR_W-1:0]  tail,
  input  logic              busy,
  input  logic              set_done,
  input  logic              set_err,
  output logic [ADDR_W-1:0] base,
  output logic [PTR_W-1:0]  ring_last,
  output logic [PTR_W-1:0]  head,
  output logic              go,
  output logic              irq_done,
  output logic              irq_err,
  output logic [1:0]        speed_sel
);
  localparam int HI_W = ADDR_W - 32;

  logic err_ie;
  logic stat_wr;

  assign stat_wr = reg_we && (reg_addr == RA_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base      <= '0;
      ring_last <= '0;
      head      <= '0;
      go        <= 1'b0;
      err_ie    <= 1'b0;
      speed_sel <= 2'b00;
    end else if (reg_we) begin
      case (reg_addr)
        RA_BASE_LO: base[31:0] <= reg_wdata;
        RA_BASE_HI: base[ADDR_W-1:32] <= reg_wdata[HI_W-1:0];
        RA_CTRL: begin
          go     <= reg_wdata[CTRL_GO];
          err_ie <= reg_wdata[CTRL_ERRIE];
          head   <= reg_wdata[PTR_LSB +: PTR_W];
        end
        RA_SIZE:   ring_last <= reg_wdata[PTR_W-1:0];
        RA_TIMING: speed_sel <= reg_wdata[31:30];
        default: ;
      endcase
    end
  end

  // Sticky interrupt bits: a new event wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      if (set_done)
        irq_done <= 1'b1;
      else if (stat_wr && reg_wdata[STAT_DONE])
        irq_done <= 1'b0;
      if (set_err && err_ie)
        irq_err <= 1'b1;
      else if (stat_wr && reg_wdata[STAT_ERR])
        irq_err <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_BASE_LO: reg_rdata = base[31:0];
      RA_BASE_HI: reg_rdata[HI_W-1:0] = base[ADDR_W-1:32];
      RA_CTRL: begin
        reg_rdata[CTRL_GO]            = go;
        reg_rdata[CTRL_ERRIE]         = err_ie;
        reg_rdata[PTR_LSB +: PTR_W]   = head;
      end
      RA_STAT: begin
        reg_rdata[STAT_BUSY]          = busy;
        reg_rdata[STAT_ERR]           = irq_err;
        reg_rdata[STAT_DONE]          = irq_done;
        reg_rdata[PTR_LSB +: PTR_W]   = tail;
      end
      RA_SIZE:   reg_rdata[PTR_W-1:0] = ring_last;
      RA_TIMING: reg_rdata[31:30]     = speed_sel;
      default: ;
    endcase
  end
endmodule

// File: rtl/dring_seq.sv
module dring_seq
  import dring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W-1:0]  ring_last,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [3:0]        mem_req_wstrb,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              exec_valid,
  input  logic              exec_ready,
  output logic [7:0]        exec_tgt,
  output logic [7:0]        exec_wr_len,
  output logic [7:0]        exec_rd_len,
  output logic [7:0]        exec_ctrl,
  output logic [63:0]       exec_dptr,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [7:0]        res_status,
  input  logic [7:0]        res_rx_cnt,
  input  logic [7:0]        res_tx_cnt,
  output logic [PTR_W-1:0]  tail,
  output logic              busy,
  output logic              set_done,
  output logic              set_err
);
  localparam int SLOT_SH = 4;             // 16-byte descriptors
  localparam logic [1:0] W_HDR = 2'd0;    // word 0: header bytes
  localparam logic [1:0] W_RES = 2'd1;    // word 1: result bytes
  localparam logic [1:0] W_PLO = 2'd2;    // word 2: pointer low
  localparam logic [1:0] W_PHI = 2'd3;    // word 3: pointer high
  localparam logic [3:0] WB_STRB = 4'b1101;

  seq_state_t          state;
  logic [1:0]          widx;
  logic [31:0]         hdr_q, plo_q, phi_q;
  logic [7:0]          st_q, rx_q, tx_q;
  logic [PTR_W-1:0]    tail_nx;
  logic [ADDR_W-1:0]   slot_addr;
  logic                wb_fire;

  assign tail_nx   = (tail == ring_last) ? '0 : tail + 1'b1;
  assign slot_addr = base + (ADDR_W'(tail) << SLOT_SH);
  assign wb_fire   = (state == S_WB) && mem_req_ready;
  assign busy      = (state != S_IDLE);

  assign exec_valid  = (state == S_EXEC);
  assign exec_tgt    = hdr_q[7:0];
  assign exec_wr_len = hdr_q[15:8];
  assign exec_rd_len = hdr_q[23:16];
  assign exec_ctrl   = hdr_q[31:24];
  assign exec_dptr   = {phi_q, plo_q};
  assign res_ready   = (state == S_WAIT);

  assign set_done = wb_fire && hdr_q[24 + DESC_IRQ];
  assign set_err  = wb_fire && !st_q[RES_OK];

  always_comb begin
    mem_req_valid = (state == S_RD_REQ) || (state == S_WB);
    mem_req_write = (state == S_WB);
    mem_req_wstrb = mem_req_write ? WB_STRB : 4'b0000;
    mem_req_wdata = {tx_q, rx_q, 8'h00, st_q};
    mem_req_addr  = slot_addr + ADDR_W'({(mem_req_write ? W_RES : widx), 2'b00});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      widx  <= W_HDR;
      tail  <= '0;
      hdr_q <= '0;
      plo_q <= '0;
      phi_q <= '0;
      st_q  <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (go && (tail != head)) begin
          state <= S_RD_REQ;
          widx  <= W_HDR;
        end
        S_RD_REQ: if (mem_req_ready) state <= S_RD_RSP;
        S_RD_RSP: if (mem_rsp_valid) begin
          case (widx)
            W_HDR:   hdr_q <= mem_rsp_data;
            W_PLO:   plo_q <= mem_rsp_data;
            default: phi_q <= mem_rsp_data;
          endcase
          if (widx == W_PHI) begin
            state <= S_EXEC;
          end else begin
            state <= S_RD_REQ;
            widx  <= (widx == W_HDR) ? W_PLO : W_PHI;
          end
        end
        S_EXEC: if (exec_ready) state <= S_WAIT;
        S_WAIT: if (res_valid) begin
          st_q  <= res_status;
          rx_q  <= res_rx_cnt;
          tx_q  <= res_tx_cnt;
          state <= S_WB;
        end
        S_WB: if (mem_req_ready) begin
          tail <= tail_nx;
          widx <= W_HDR;
          state <= (go && (tail_nx != head)) ? S_RD_REQ : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [3:0]        mem_req_wstrb,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              exec_valid,
  input  logic              exec_ready,
  output logic [7:0]        exec_tgt,
  output logic [7:0]        exec_wr_len,
  output logic [7:0]        exec_rd_len,
  output logic [7:0]        exec_ctrl,
  output logic [63:0]       exec_dptr,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [7:0]        res_status,
  input  logic [7:0]        res_rx_cnt,
  input  logic [7:0]        res_tx_cnt,
  output logic              irq,
  output logic [1:0]        speed_sel
);
  logic [PTR_W-1:0]  tail_w, head_w, last_w;
  logic [ADDR_W-1:0] base_w;
  logic              go_w, busy_w, set_done_w, set_err_w, done_w, err_w;

  dring_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tail(tail_w), .busy(busy_w), .set_done(set_done_w), .set_err(set_err_w),
    .base(base_w), .ring_last(last_w), .head(head_w), .go(go_w),
    .irq_done(done_w), .irq_err(err_w), .speed_sel(speed_sel)
  );

  dring_seq #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go_w), .head(head_w), .ring_last(last_w), .base(base_w),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_wstrb(mem_req_wstrb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .exec_valid(exec_valid), .exec_ready(exec_ready),
    .exec_tgt(exec_tgt), .exec_wr_len(exec_wr_len), .exec_rd_len(exec_rd_len),
    .exec_ctrl(exec_ctrl), .exec_dptr(exec_dptr),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_status(res_status), .res_rx_cnt(res_rx_cnt), .res_tx_cnt(res_tx_cnt),
    .tail(tail_w), .busy(busy_w), .set_done(set_done_w), .set_err(set_err_w)
  );

  assign irq = done_w | err_w;
endmodule

// File: rtl/dring_chk.sv
module dring_chk #(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              exec_valid,
  input logic              exec_ready,
  input logic [7:0]        exec_ctrl,
  input logic [PTR_W-1:0]  tail,
  input logic              busy,
  input logic              irq_done,
  input logic              irq_err
);
  logic wb_acc;
  assign wb_acc = mem_req_valid && mem_req_ready && mem_req_write;

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R4
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid && !exec_ready |=> exec_valid && $stable(exec_ctrl));

  // R6
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tail) |-> $past(wb_acc));

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> $past(wb_acc));

  // R10
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> $past(wb_acc));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !exec_valid);
endmodule

bind dring_ctrl dring_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .exec_valid(exec_valid), .exec_ready(exec_ready), .exec_ctrl(exec_ctrl),
  .tail(tail_w), .busy(busy_w), .irq_done(done_w), .irq_err(err_w)
);

// File: tb/sim_dring_ctrl.sv
module sim_dring_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0002_0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic [3:0]  mem_req_wstrb;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        exec_valid;
  logic        exec_ready = 1'b0;
  logic [7:0]  exec_tgt, exec_wr_len, exec_rd_len, exec_ctrl;
  logic [63:0] exec_dptr;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [7:0]  res_status = '0, res_rx_cnt = '0, res_tx_cnt = '0;
  logic        irq;
  logic [1:0]  speed_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  dring_ctrl u0 (.*);

  int total = 0, bad = 0, n_exec = 0;
  bit finished = 0;

  typedef struct { logic [7:0] tgt, wr, rd, ctrl; logic [63:0] dptr; } exp_desc_t;
  typedef struct { logic [63:0] addr; logic [31:0] data; } exp_wb_t;
  logic [63:0] rd_q[$];
  exp_desc_t   ex_q[$];
  exp_wb_t     wb_q[$];
  logic [31:0] mem [16];
  exp_desc_t   slot_d [4];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic write_desc(input int s, input logic [7:0] tgt, wr, rd, ctl, input logic [63:0] dp);
    slot_d[s] = '{tgt, wr, rd, ctl, dp};
    mem[s*4+0] = {ctl, rd, wr, tgt};
    mem[s*4+1] = 32'h0000_AA00;
    mem[s*4+2] = dp[31:0];
    mem[s*4+3] = dp[63:32];
  endtask

  // Driver: queue what the design must produce for slot s.
  task automatic expect_desc(input int s);
    logic [63:0] sa;
    logic [7:0]  st;
    sa = BASE + 64'(s * 16);
    rd_q.push_back(sa);
    rd_q.push_back(sa + 8);
    rd_q.push_back(sa + 12);
    ex_q.push_back(slot_d[s]);
    st = slot_d[s].ctrl[7] ? 8'h08 : 8'h01;
    wb_q.push_back('{sa + 4, {slot_d[s].wr, slot_d[s].rd, 8'h00, st}});
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd3, v);
      if (!v[0]) break;
    end
  endtask

  // Memory model and monitor for reads (R3), writeback (R5) and stalls (R12)
  initial begin
    int cyc = 0;
    bit pend = 0, stalled = 0, pw = 0;
    logic [31:0] pword = '0;
    logic [63:0] pa = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = pword; pend = 0; end
      if (stalled)
        check(mem_req_valid && mem_req_addr == pa && mem_req_write == pw, "R12 stall hold", mem_req_addr, pa);
      mem_req_ready = (cyc % 3 == 2);
      stalled = mem_req_valid && !mem_req_ready;
      pa = mem_req_addr; pw = mem_req_write;
      if (mem_req_valid && mem_req_ready) begin
        int idx;
        idx = int'((mem_req_addr - BASE) >> 2) & 15;
        if (!mem_req_write) begin
          logic [63:0] ea;
          ea = (rd_q.size() > 0) ? rd_q.pop_front() : 64'hDEAD;
          check(mem_req_addr == ea, "R3 read address", mem_req_addr, ea);
          pword = mem[idx]; pend = 1;
        end else begin
          exp_wb_t e;
          logic [31:0] m;
          e = (wb_q.size() > 0) ? wb_q.pop_front() : '{64'hDEAD, 32'h0};
          check(mem_req_addr == e.addr, "R5 writeback address", mem_req_addr, e.addr);
          check((mem_req_wdata & 32'hFFFF00FF) == e.data, "R5 writeback data", mem_req_wdata, e.data);
          check(mem_req_wstrb == 4'b1101, "R5 writeback strobe", 64'(mem_req_wstrb), 64'hD);
          for (int b = 0; b < 4; b++) begin
            m = {{8{mem_req_wstrb[b]}}} << (8*b);
            mem[idx] = (mem[idx] & ~m) | (mem_req_wdata & m);
          end
        end
      end
    end
  end

  // Executor model and monitor for the hand-off (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (exec_valid) begin
        exp_desc_t e, g;
        repeat (2) @(negedge clk);
        exec_ready = 1'b1;
        g = '{exec_tgt, exec_wr_len, exec_rd_len, exec_ctrl, exec_dptr};
        e = (ex_q.size() > 0) ? ex_q.pop_front() : '{8'h0, 8'h0, 8'h0, 8'h0, 64'hDEAD};
        check(g.tgt == e.tgt && g.wr == e.wr && g.rd == e.rd && g.ctrl == e.ctrl,
              "R4 handoff bytes", {32'h0, g.tgt, g.wr, g.rd, g.ctrl}, {32'h0, e.tgt, e.wr, e.rd, e.ctrl});
        check(g.dptr == e.dptr, "R4 handoff pointer", g.dptr, e.dptr);
        n_exec++;
        @(negedge clk); exec_ready = 1'b0;
        repeat (3) @(negedge clk);
        res_valid  = 1'b1;
        res_status = g.ctrl[7] ? 8'h08 : 8'h01;
        res_rx_cnt = g.rd;
        res_tx_cnt = g.wr;
        while (!res_ready) @(negedge clk);
        @(negedge clk); res_valid = 1'b0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(mem_req_valid == 1'b0, "R1 no request", 64'(mem_req_valid), 0);
    reg_rd(3'd3, v); check(v == 0, "R1 status", v, 0);
    reg_rd(3'd2, v); check(v == 0, "R1 control", v, 0);
    check(irq == 1'b0, "R1 irq", 64'(irq), 0);

    // R2 register readback and speed encoding
    reg_wr(3'd0, BASE[31:0]);  reg_rd(3'd0, v); check(v == BASE[31:0], "R2 base low", v, BASE[31:0]);
    reg_wr(3'd1, BASE[63:32]); reg_rd(3'd1, v); check(v == BASE[63:32], "R2 base high", v, BASE[63:32]);
    reg_wr(3'd4, 32'd3);       reg_rd(3'd4, v); check(v == 3, "R2 ring size", v, 3);
    for (int s = 0; s < 4; s++) begin
      reg_wr(3'd5, {2'(s), 30'h0});
      reg_rd(3'd5, v);
      check(v == {2'(s), 30'h0} && speed_sel == 2'(s), "R2 timing speed", {v[31:30], speed_sel}, {2'(s), 2'(s)});
    end

    // Run A: completion on slot 0, error on slot 1, error interrupt enabled
    write_desc(0, 8'hA1, 8'h03, 8'h02, 8'h40, 64'h1111_2222_3333_4444);
    write_desc(1, 8'hB4, 8'h05, 8'h00, 8'h80, 64'h0000_0009_8765_4320);
    expect_desc(0); expect_desc(1);
    reg_wr(3'd2, 32'h0002_0011);
    wait_idle();
    reg_rd(3'd3, v); check(v == 32'h0002_0030, "R6 R9 R10 status after run A", v, 32'h0002_0030);
    check(irq == 1'b1, "R11 irq asserted", 64'(irq), 1);
    check(mem[1] == 32'h0302_AA01, "R5 retry byte kept", mem[1], 32'h0302_AA01);
    reg_wr(3'd3, 32'h0);        reg_rd(3'd3, v); check(v == 32'h0002_0030, "R11 write 0 keeps", v, 32'h0002_0030);
    reg_wr(3'd3, 32'h20);       reg_rd(3'd3, v); check(v == 32'h0002_0010, "R11 clear done", v, 32'h0002_0010);
    check(irq == 1'b1, "R11 irq held by error", 64'(irq), 1);
    reg_wr(3'd3, 32'h10);       reg_rd(3'd3, v); check(v == 32'h0002_0000, "R11 clear error", v, 32'h0002_0000);
    check(irq == 1'b0, "R11 irq released", 64'(irq), 0);

    // Run B: wrap to 0, error interrupt disabled, no completion request
    write_desc(2, 8'hC0, 8'h01, 8'h04, 8'h80, 64'h0);
    write_desc(3, 8'hD3, 8'h02, 8'h01, 8'h00, 64'hFFFF_0000_FFFF_0000);
    expect_desc(2); expect_desc(3);
    reg_wr(3'd2, 32'h0000_0001);
    wait_idle();
    reg_rd(3'd3, v); check(v == 32'h0, "R6 R10 wrap no irq", v, 0);
    check(irq == 1'b0, "R9 no completion bit", 64'(irq), 0);

    // Run C: stop after the in-flight descriptor, then resume
    write_desc(0, 8'h10, 8'h07, 8'h03, 8'h40, 64'h5);
    write_desc(1, 8'h12, 8'h08, 8'h02, 8'h00, 64'h6);
    write_desc(2, 8'h14, 8'h09, 8'h01, 8'h40, 64'h7);
    expect_desc(0);
    k = n_exec;
    reg_wr(3'd2, 32'h0003_0001);
    wait (n_exec == k + 1);
    reg_rd(3'd3, v); check(v[0] == 1'b1, "R7 busy while running", 64'(v[0]), 1);
    reg_wr(3'd2, 32'h0003_0000);
    wait_idle();
    reg_rd(3'd3, v); check(v == 32'h0001_0020, "R8 stopped after one", v, 32'h0001_0020);
    repeat (20) @(negedge clk);
    check(n_exec == k + 1, "R8 no further hand-off", 64'(n_exec), 64'(k + 1));
    expect_desc(1); expect_desc(2);
    reg_wr(3'd2, 32'h0003_0001);
    wait_idle();
    reg_rd(3'd3, v); check(v == 32'h0003_0020, "R8 R7 resumed to head", v, 32'h0003_0020);
    check(rd_q.size() == 0 && ex_q.size() == 0 && wb_q.size() == 0, "R3 all expected traffic seen",
          64'(rd_q.size() + ex_q.size() + wb_q.size()), 0);
    finish_run();
  end
endmodule